// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around one accumulator. It runs each instruction as a visible sequence of fetch, decode and execute steps. Every step is its own control state and moves a value between the program counter, the memory address register, the memory data register, the instruction register and the accumulator. Instructions and data sit in one shared memory. The core reaches that memory through a single port with an address, a read strobe, a write strobe and a write-data bus. Read data comes back one clock after the read strobe.

An instruction word is 12 bits wide. Bits [11:8] hold the opcode and bits [7:0] hold a memory address. The opcodes are: 0 halt, 1 add, 2 subtract, 3 store, 5 load, 6 jump, 7 jump-if-zero and 8 jump-if-non-negative. Any other opcode does nothing. Data words are 12-bit two's complement. The accumulator value and a halted flag are brought out as outputs, so results can be observed.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, mem_rd, mem_wr and halted are 0 and acc_value is 0. The first instruction is fetched from address 0.
- R2: Each instruction takes five cycles before any execute step: address setup, read, capture, instruction-register load and decode. mem_rd is high in the second of these cycles, with mem_addr equal to the program counter.
- R3: If an instruction is not a taken jump, the next fetch reads the address one higher, modulo 256.
- R4: Load (opcode 5) reads the word at its address field in cycle 6 of the instruction. That word is in acc_value from the next instruction's first cycle. The instruction takes 8 cycles.
- R5: Add (opcode 1) and subtract (opcode 2) read their operand in the same way as load. They replace the accumulator with acc + M or acc − M, modulo 4096, after 8 cycles.
- R6: Store (opcode 3) drives mem_wr with mem_addr equal to its address field and mem_wdata equal to the accumulator in cycle 6. The instruction takes 6 cycles.
- R7: Jump (opcode 6) always makes the next fetch read its address field. The instruction takes 5 cycles.
- R8: Jump-if-zero (opcode 7) goes to its address field only when the accumulator is 0. Otherwise execution falls through.
- R9: Jump-if-non-negative (opcode 8) goes to its address field only when accumulator bit 11 is 0. This includes an accumulator of 0.
- R10: Halt (opcode 0) sets halted from the cycle after its decode step. From then until reset the core makes no further memory access and the accumulator keeps its value.
- R11: Opcodes 4 and 9 to 15 take 5 cycles, make no data access and leave the accumulator unchanged.
- R12: mem_rd and mem_wr are never high in the same cycle. Two reads never occur in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Shared memory address (memory address register) |
| mem_rd | output | 1 | Read request; data is returned on the next clock |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 12 | Write data (memory data register) |
| mem_rdata | input | 12 | Read data, valid one clock after mem_rd |
| acc_value | output | 12 | Current accumulator contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check on every cycle that a read and a write never coincide, that reads are never back to back, and that halted stays set and keeps the memory port quiet. They also check that store data equals the accumulator and that the accumulator does not move in the cycle after a read. Only the bench's programs can show the instruction-level behaviour. That covers the exact cycle of each access, the address of each fetch after taken and untaken jumps, zero counting as non-negative, wraparound of add and subtract, and memory contents after stores. A reference model in the bench predicts these values.

// File: rtl/acc_cpu_pkg.sv
// Package: shared types for the accumulator processor core.
// Holds the opcode encoding, the control-state encoding, the ALU
// selector and the bundle of datapath strobes issued by the controller.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HLT = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_STA = 4'd3,
        OP_LDA = 4'd5,
        OP_BRA = 4'd6,
        OP_BRZ = 4'd7,
        OP_BRP = 4'd8
    } opcode_t;

    typedef enum logic [3:0] {
        ST_F_ADDR,
        ST_F_READ,
        ST_F_CAPT,
        ST_F_LOAD,
        ST_DECODE,
        ST_X_READ,
        ST_X_CAPT,
        ST_X_ALU,
        ST_X_WRITE,
        ST_HALT
    } state_t;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_sel_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_cir;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic cir_from_mdr;
        logic pc_inc;
        logic pc_load;
        logic acc_load;
        logic mem_rd;
        logic mem_wr;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Module: acc_cpu_alu
// Combinational arithmetic unit. It combines the accumulator (a) with
// the memory data register (b), or passes b through. It also derives
// the zero and sign flags of the accumulator for jump decisions.
// Assumes two's complement words of DATA_W bits; overflow wraps.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_sel_t          sel,
    output logic [DATA_W-1:0] y,
    output logic              a_zero,
    output logic              a_neg
);

    // Result select: add, subtract or pass the memory operand.
    always_comb begin
        case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end

    // Flags of the accumulator used by the conditional jumps.
    always_comb begin
        a_zero = (a == '0);
        a_neg  = a[DATA_W-1];
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module: acc_cpu_ctrl
// Control unit. A state machine with one state per fetch, decode and
// execute step. Each state issues the strobes that move one value
// between registers or across the shared memory port.
// Assumes memory read data is valid in the cycle after mem_rd.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  opcode_t  opcode,
    input  logic     acc_zero,
    input  logic     acc_neg,
    output ctrl_t    ctl,
    output alu_sel_t alu_sel,
    output logic     halted
);

    state_t state;
    state_t state_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_F_ADDR;
        else        state <= state_nx;
    end

    // Strobe and next-state decode for the current step.
    always_comb begin
        ctl      = '0;
        alu_sel  = ALU_PASS;
        state_nx = state;
        case (state)
            ST_F_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                state_nx        = ST_F_READ;
            end
            ST_F_READ: begin
                ctl.mem_rd = 1'b1;
                state_nx   = ST_F_CAPT;
            end
            ST_F_CAPT: begin
                ctl.mdr_from_mem = 1'b1;
                state_nx         = ST_F_LOAD;
            end
            ST_F_LOAD: begin
                ctl.cir_from_mdr = 1'b1;
                ctl.pc_inc       = 1'b1;
                state_nx         = ST_DECODE;
            end
            ST_DECODE: begin
                state_nx = ST_F_ADDR;
                case (opcode)
                    OP_HLT: state_nx = ST_HALT;
                    OP_ADD, OP_SUB, OP_LDA: begin
                        ctl.mar_from_cir = 1'b1;
                        state_nx         = ST_X_READ;
                    end
                    OP_STA: begin
                        ctl.mar_from_cir = 1'b1;
                        ctl.mdr_from_acc = 1'b1;
                        state_nx         = ST_X_WRITE;
                    end
                    OP_BRA: ctl.pc_load = 1'b1;
                    OP_BRZ: ctl.pc_load = acc_zero;
                    OP_BRP: ctl.pc_load = !acc_neg;
                    default: ;
                endcase
            end
            ST_X_READ: begin
                ctl.mem_rd = 1'b1;
                state_nx   = ST_X_CAPT;
            end
            ST_X_CAPT: begin
                ctl.mdr_from_mem = 1'b1;
                state_nx         = ST_X_ALU;
            end
            ST_X_ALU: begin
                ctl.acc_load = 1'b1;
                case (opcode)
                    OP_ADD:  alu_sel = ALU_ADD;
                    OP_SUB:  alu_sel = ALU_SUB;
                    default: alu_sel = ALU_PASS;
                endcase
                state_nx = ST_F_ADDR;
            end
            ST_X_WRITE: begin
                ctl.mem_wr = 1'b1;
                state_nx   = ST_F_ADDR;
            end
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_F_ADDR;
        endcase
    end

    // Halt indication for the outside world.
    always_comb halted = (state == ST_HALT);

endmodule

// File: rtl/acc_cpu_datapath.sv
// Module: acc_cpu_datapath
// Named registers of the core: program counter, memory address
// register, memory data register, instruction register and
// accumulator. Each register moves only on a controller strobe.
// Assumes the controller never raises two sources of one register
// in the same cycle.
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_y,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic [DATA_W-1:0] acc_q,
    output opcode_t           opcode
);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] cir_q;
    logic [ADDR_W-1:0] cir_addr;

    // Split the instruction into its address and opcode fields.
    always_comb begin
        cir_addr = cir_q[ADDR_W-1:0];
        opcode   = opcode_t'(cir_q[DATA_W-1 -: OPC_W]);
    end

    // Program counter: jump target load or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)           pc_q <= '0;
        else if (ctl.pc_load) pc_q <= cir_addr;
        else if (ctl.pc_inc)  pc_q <= pc_q + 1'b1;
    end

    // Memory address register: from PC for fetch, from operand for execute.
    always_ff @(posedge clk) begin
        if (!rst_n)                mar_q <= '0;
        else if (ctl.mar_from_pc)  mar_q <= pc_q;
        else if (ctl.mar_from_cir) mar_q <= cir_addr;
    end

    // Memory data register: capture read data or stage store data.
    always_ff @(posedge clk) begin
        if (!rst_n)                mdr_q <= '0;
        else if (ctl.mdr_from_mem) mdr_q <= mem_rdata;
        else if (ctl.mdr_from_acc) mdr_q <= acc_q;
    end

    // Instruction register: loaded from the memory data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                cir_q <= '0;
        else if (ctl.cir_from_mdr) cir_q <= mdr_q;
    end

    // Accumulator: written with the ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (ctl.acc_load) acc_q <= alu_y;
    end

endmodule

// File: rtl/acc_cpu_core.sv
// Module: acc_cpu_core
// Top of the accumulator processor. Connects the control unit, the
// register datapath and the ALU to one shared instruction/data port.
// Assumes a synchronous memory that returns read data one clock
// after mem_rd. Only one access is made per cycle.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_value,
    output logic              halted
);

    ctrl_t             ctl;
    alu_sel_t          alu_sel;
    opcode_t           opcode;
    logic              acc_zero;
    logic              acc_neg;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] mar_q;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ctl      (ctl),
        .alu_sel  (alu_sel),
        .halted   (halted)
    );

    acc_cpu_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .alu_y     (alu_y),
        .mar_q     (mar_q),
        .mdr_q     (mdr_q),
        .acc_q     (acc_q),
        .opcode    (opcode)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a      (acc_q),
        .b      (mdr_q),
        .sel    (alu_sel),
        .y      (alu_y),
        .a_zero (acc_zero),
        .a_neg  (acc_neg)
    );

    // Memory port driven straight from the address and data registers.
    always_comb begin
        mem_addr  = mar_q;
        mem_wdata = mdr_q;
        mem_rd    = ctl.mem_rd;
        mem_wr    = ctl.mem_wr;
        acc_value = acc_q;
    end

endmodule

// File: rtl/acc_cpu_checker.sv
// Module: acc_cpu_checker
// Protocol checks on the memory port and halt behaviour of
// acc_cpu_core. It is attached to the core with a bind statement.
module acc_cpu_checker #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] acc_value,
    input logic          halted
);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R12
    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R10
    AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc_value)); // R6
    AST_ACC_HOLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(acc_value)); // R4

endmodule

bind acc_cpu_core acc_cpu_checker #(.DW(DATA_W)) u_chk (.*);

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
// Bench for acc_cpu_core. A behavioural model runs each instruction
// and queues the port values expected in every cycle. Each cycle the
// DUT is compared with the next queued entry.
module tb_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic [11:0] acc_value;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    acc_cpu_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_value(acc_value), .halted(halted)
    );

    // Synchronous memory seen by the DUT.
    logic [11:0] mem [256];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    // Model state.
    logic [11:0] mmem [256];
    logic [7:0]  mpc;
    logic [11:0] macc;
    bit          mhalt;
    string       fetch_tag;

    bit          q_rd[$];
    bit          q_wr[$];
    logic [7:0]  q_addr[$];
    logic [11:0] q_wdata[$];
    logic [11:0] q_acc[$];
    bit          q_hlt[$];
    string       q_tag[$];

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push(bit rd, bit wr, logic [7:0] a, logic [11:0] d, string tag);
        q_rd.push_back(rd); q_wr.push_back(wr); q_addr.push_back(a);
        q_wdata.push_back(d); q_acc.push_back(macc); q_hlt.push_back(mhalt);
        q_tag.push_back(tag);
    endtask

    // Run one instruction in the model and queue its cycles.
    task automatic model_step();
        logic [11:0] ir = mmem[mpc];
        logic [3:0]  op = ir[11:8];
        logic [7:0]  a  = ir[7:0];
        string t;
        case (op)
            4'd0: t = "R10";
            4'd1, 4'd2: t = "R5";
            4'd3: t = "R6";
            4'd5: t = "R4";
            4'd6: t = "R7";
            4'd7: t = "R8";
            4'd8: t = "R9";
            default: t = "R11";
        endcase
        push(0, 0, 8'h0, 12'h0, fetch_tag);
        push(1, 0, mpc, 12'h0, fetch_tag);      // R2 fetch read
        push(0, 0, 8'h0, 12'h0, "R12");
        push(0, 0, 8'h0, 12'h0, "R12");
        push(0, 0, 8'h0, 12'h0, t);            // decode
        mpc = mpc + 8'd1;                      // R3
        fetch_tag = "R3";
        case (op)
            4'd0: mhalt = 1;                   // R10
            4'd1, 4'd2, 4'd5: begin
                push(1, 0, a, 12'h0, t);
                push(0, 0, 8'h0, 12'h0, t);
                push(0, 0, 8'h0, 12'h0, t);
                if (op == 4'd1) macc = macc + mmem[a];
                else if (op == 4'd2) macc = macc - mmem[a];
                else macc = mmem[a];
            end
            4'd3: begin
                push(0, 1, a, macc, t);
                mmem[a] = macc;
            end
            4'd6: begin mpc = a; fetch_tag = "R7"; end
            4'd7: begin fetch_tag = "R8"; if (macc == 12'h0) mpc = a; end
            4'd8: begin fetch_tag = "R9"; if (!macc[11]) mpc = a; end
            default: ;
        endcase
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 12'h0;
            mmem[i] = 12'h0;
        end
    endtask

    task automatic put(int a, logic [11:0] w);
        mem[a] = w;
        mmem[a] = w;
    endtask

    // Reset the DUT and model, then compare every cycle until halted.
    task automatic run_program();
        int halt_cycles = 0;
        rst_n = 1'b0;
        mpc = 8'h0; macc = 12'h0; mhalt = 0; fetch_tag = "R1";
        q_rd.delete(); q_wr.delete(); q_addr.delete(); q_wdata.delete();
        q_acc.delete(); q_hlt.delete(); q_tag.delete();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(!mem_rd && !mem_wr && !halted && acc_value == 12'h0, "R1", "reset",
              {mem_rd, mem_wr, halted, acc_value}, 32'h0);
        rst_n = 1'b1;
        while (halt_cycles < 4) begin
            bit erd, ewr, ehlt;
            logic [7:0] ea;
            logic [11:0] ed, eacc;
            string et;
            if (q_rd.size() == 0) begin
                if (mhalt) push(0, 0, 8'h0, 12'h0, "R10");
                else model_step();
            end
            erd = q_rd.pop_front(); ewr = q_wr.pop_front(); ea = q_addr.pop_front();
            ed = q_wdata.pop_front(); eacc = q_acc.pop_front(); ehlt = q_hlt.pop_front();
            et = q_tag.pop_front();
            check(mem_rd == erd && mem_wr == ewr && (!(erd || ewr) || mem_addr == ea)
                  && (!ewr || mem_wdata == ed), et, "bus",
                  {10'h0, mem_rd, mem_wr, mem_addr, mem_wdata}, {10'h0, erd, ewr, ea, ed});
            check(acc_value == eacc, et, "acc", {20'h0, acc_value}, {20'h0, eacc});
            check(halted == ehlt, et, "halted", {31'h0, halted}, {31'h0, ehlt});
            if (ehlt) halt_cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        // Program 1: load, add with wrap into the sign bit, subtract, store.
        clear_mem();
        put(0, 12'h514); put(1, 12'h115); put(2, 12'h216); put(3, 12'h317); put(4, 12'h000);
        put(20, 12'd100); put(21, 12'd2000); put(22, 12'd50);
        run_program();
        check(mem[23] == 12'h802, "R6", "stored sum", {20'h0, mem[23]}, 32'h802);
        check(acc_value == 12'h802, "R5", "final acc", {20'h0, acc_value}, 32'h802);

        // Program 2: jumps on zero, non-negative, negative, no-ops, store, jump.
        clear_mem();
        put(0, 12'h51E); put(1, 12'h704); put(4, 12'h807); put(7, 12'h21F);
        put(8, 12'h802); put(9, 12'h702); put(10, 12'h41F); put(11, 12'hF00);
        put(12, 12'h320); put(13, 12'h60F); put(14, 12'h000);
        put(15, 12'h121); put(16, 12'h322); put(17, 12'h000);
        put(31, 12'd1); put(33, 12'd5);
        put(2, 12'h000); put(3, 12'h000); put(5, 12'h000); put(6, 12'h000);
        run_program();
        check(mem[32] == 12'hFFF, "R11", "acc kept over no-ops", {20'h0, mem[32]}, 32'hFFF);
        check(mem[34] == 12'h004, "R7", "after jump", {20'h0, mem[34]}, 32'h004);
        check(mem[31] == 12'h001 && mem[33] == 12'h005, "R4", "operands intact",
              {8'h0, mem[31], mem[33]}, {8'h0, 12'h001, 12'h005});

        // Program 3: count-down loop with store and conditional exit.
        clear_mem();
        put(0, 12'h528); put(1, 12'h229); put(2, 12'h328); put(3, 12'h705);
        put(4, 12'h601); put(5, 12'h000); put(40, 12'd3); put(41, 12'd1);
        run_program();
        check(mem[40] == 12'h000, "R8", "loop result", {20'h0, mem[40]}, 32'h0);
        check(halted == 1'b1, "R10", "halted held", {31'h0, halted}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule